// File: doc/BRIEF.md
# Paged Program Window Address Expander

This block turns a 16-bit local address from the processor into an 18-bit global program-space address. Local addresses 0x8000–0xBFFF form a 16 KB paged window. An access inside the window takes its upper global bits from the low four bits of a page register. Those four bits select one of sixteen 16 KB blocks, so the window reaches 256 KB. The other three quarters of the local space map to fixed global pages.

Two 8-bit page registers sit behind one small register port. The processor page register serves normal accesses. The debug page register replaces it for debug-originated accesses, provided its feature is enabled. Both registers expand addresses in the same way.

During active debug mode the block also watches for a firmware overlay. When the processor page register holds 0xFF, accesses to 0xBF00–0xBFFF are flagged so that the debug tables answer instead of flash.

Top module: `pgx_top`

## Requirements
- R1: A local address in 0x8000–0xBFFF asserts `page_hit` in the same cycle and drives `glb_addr` = {page[3:0], loc_addr[13:0]}.
- R2: A local address in 0xC000–0xFFFF drives `glb_addr` = {4'hF, loc_addr[13:0]} and deasserts `page_hit`, whatever either page register holds.
- R3: A local address in 0x4000–0x7FFF maps to {4'hE, loc_addr[13:0]}, and one in 0x0000–0x3FFF maps to {4'h0, loc_addr[13:0]}. Both deassert `page_hit`.
- R4: After reset both page registers read 0x00. `reg_rdata` shows the full 8 bits of the register chosen by `reg_sel`: 0 chooses the processor register, 1 chooses the debug register.
- R5: All 8 written bits are stored, but only bits [3:0] take part in address expansion. For example, 0xA5 selects page 5.
- R6: A write (`reg_we`=1 at a rising edge) changes neither `glb_addr` nor `reg_rdata` before that edge. The new value applies from the cycle that follows.
- R7: The debug page register supplies the page only while both `dbg_access` and `dbg_page_en` are 1. Otherwise the processor page register supplies it.
- R8: `ovl_sel` is 1 exactly when `dbg_active` is 1, the processor page register equals 0xFF in all 8 bits, and `loc_addr` lies in 0xBF00–0xBFFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| loc_addr | input | 16 | Local address of the current access |
| dbg_access | input | 1 | Access comes from a debug command |
| dbg_page_en | input | 1 | Debug page register feature enabled |
| dbg_active | input | 1 | Active debug mode |
| reg_sel | input | 1 | Register choice: 0 processor page, 1 debug page |
| reg_we | input | 1 | Write strobe for the chosen register |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data of the chosen register |
| glb_addr | output | 18 | Expanded global address |
| ovl_sel | output | 1 | Debug firmware overlay selected |
| page_hit | output | 1 | Access falls inside the paged window |

## Verification
The hardest case to reach is an overlay miss where the page register almost matches. A value such as 0x0F drives the same expansion bits as 0xFF, so only the full 8-bit compare can tell the two apart. The stimulus writes 0x0F and then 0xFF through the register port, keeping the address and debug mode fixed, and expects `ovl_sel` only for 0xFF. A second case is the single-cycle write latency. Here the output is sampled both before and after the capturing edge while the write strobe is held.

// File: rtl/pgx_pkg.sv
package pgx_pkg;
  typedef enum logic [1:0] {
    RG_LOW = 2'b00,
    RG_MID = 2'b01,
    RG_WIN = 2'b10,
    RG_TOP = 2'b11
  } region_t;

  function automatic region_t region_of(input logic [1:0] top_bits);
    region_t r;
    case (top_bits)
      2'b00:   r = RG_LOW;
      2'b01:   r = RG_MID;
      2'b10:   r = RG_WIN;
      default: r = RG_TOP;
    endcase
    return r;
  endfunction
endpackage

// File: rtl/pgx_rst_sync.sv
module pgx_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/pgx_page_regs.sv
module pgx_page_regs #(
  parameter int PG_W  = 8,
  parameter int N_REG = 2,
  localparam int SEL_W = (N_REG > 1) ? $clog2(N_REG) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SEL_W-1:0] sel,
  input  logic             we,
  input  logic [PG_W-1:0]  wdata,
  output logic [PG_W-1:0]  rdata,
  output logic [PG_W-1:0]  page_q [N_REG]
);
  for (genvar i = 0; i < N_REG; i++) begin : g_reg
    logic [PG_W-1:0] nxt;
    logic            wen;

    always_comb begin
      wen = we && (sel == SEL_W'(i));
      nxt = wen ? wdata : page_q[i];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) page_q[i] <= '0;
      else        page_q[i] <= nxt;
    end
  end

  always_comb begin
    rdata = '0;
    for (int k = 0; k < N_REG; k++) begin
      if (sel == SEL_W'(k)) rdata = page_q[k];
    end
  end
endmodule

// File: rtl/pgx_addr_map.sv
module pgx_addr_map
  import pgx_pkg::*;
#(
  parameter int              LA_W     = 16,
  parameter int              IDX_W    = 4,
  parameter logic [IDX_W-1:0] FIX_TOP = 4'hF,
  parameter logic [IDX_W-1:0] FIX_MID = 4'hE,
  parameter logic [IDX_W-1:0] FIX_LOW = 4'h0,
  localparam int OFS_W = LA_W - 2,
  localparam int GA_W  = IDX_W + OFS_W
) (
  input  logic [LA_W-1:0]  loc_addr,
  input  logic [IDX_W-1:0] idx_cpu,
  input  logic [IDX_W-1:0] idx_dbg,
  input  logic             use_dbg,
  output logic [GA_W-1:0]  glb_addr,
  output logic             in_window
);
  region_t          rgn;
  logic [IDX_W-1:0] idx_win;
  logic [IDX_W-1:0] idx_out;

  always_comb begin
    rgn     = region_of(loc_addr[LA_W-1:LA_W-2]);
    idx_win = use_dbg ? idx_dbg : idx_cpu;
    case (rgn)
      RG_WIN:  idx_out = idx_win;
      RG_TOP:  idx_out = FIX_TOP;
      RG_MID:  idx_out = FIX_MID;
      default: idx_out = FIX_LOW;
    endcase
    in_window = (rgn == RG_WIN);
    glb_addr  = {idx_out, loc_addr[OFS_W-1:0]};
  end
endmodule

// File: rtl/pgx_overlay_dec.sv
module pgx_overlay_dec #(
  parameter int              LA_W     = 16,
  parameter int              PG_W     = 8,
  parameter logic [PG_W-1:0] OVL_PAGE = 8'hFF,
  parameter logic [7:0]      OVL_HI   = 8'hBF
) (
  input  logic            dbg_active,
  input  logic [PG_W-1:0] page_cpu,
  input  logic [LA_W-1:0] loc_addr,
  output logic            ovl_sel
);
  always_comb begin
    ovl_sel = dbg_active && (page_cpu == OVL_PAGE) &&
              (loc_addr[LA_W-1:LA_W-8] == OVL_HI);
  end
endmodule

// File: rtl/pgx_top.sv
module pgx_top #(
  parameter int LA_W  = 16,
  parameter int PG_W  = 8,
  parameter int IDX_W = 4,
  localparam int GA_W = IDX_W + LA_W - 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [LA_W-1:0] loc_addr,
  input  logic            dbg_access,
  input  logic            dbg_page_en,
  input  logic            dbg_active,
  input  logic            reg_sel,
  input  logic            reg_we,
  input  logic [PG_W-1:0] reg_wdata,
  output logic [PG_W-1:0] reg_rdata,
  output logic [GA_W-1:0] glb_addr,
  output logic            ovl_sel,
  output logic            page_hit
);
  logic            rst_sync_n;
  logic [PG_W-1:0] page_q [2];
  logic            use_dbg;

  pgx_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n)
  );

  pgx_page_regs #(.PG_W(PG_W), .N_REG(2)) u_regs (
    .clk(clk), .rst_n(rst_sync_n), .sel(reg_sel), .we(reg_we),
    .wdata(reg_wdata), .rdata(reg_rdata), .page_q(page_q)
  );

  assign use_dbg = dbg_access && dbg_page_en;

  pgx_addr_map #(.LA_W(LA_W), .IDX_W(IDX_W)) u_map (
    .loc_addr(loc_addr), .idx_cpu(page_q[0][IDX_W-1:0]),
    .idx_dbg(page_q[1][IDX_W-1:0]), .use_dbg(use_dbg),
    .glb_addr(glb_addr), .in_window(page_hit)
  );

  pgx_overlay_dec #(.LA_W(LA_W), .PG_W(PG_W)) u_ovl (
    .dbg_active(dbg_active), .page_cpu(page_q[0]),
    .loc_addr(loc_addr), .ovl_sel(ovl_sel)
  );
endmodule

// File: rtl/pgx_chk.sv
module pgx_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [15:0] loc_addr,
  input logic        dbg_access,
  input logic        dbg_page_en,
  input logic        dbg_active,
  input logic        reg_sel,
  input logic        reg_we,
  input logic [7:0]  reg_wdata,
  input logic [7:0]  reg_rdata,
  input logic [17:0] glb_addr,
  input logic        ovl_sel,
  input logic        page_hit
);
  assert_window_ofs_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (loc_addr[15:14] == 2'b10) |-> (page_hit && glb_addr[13:0] == loc_addr[13:0]));

  assert_top_fixed_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (loc_addr[15:14] == 2'b11) |-> (!page_hit && glb_addr == {4'hF, loc_addr[13:0]}));

  assert_mid_fixed_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (loc_addr[15:14] == 2'b01) |-> (!page_hit && glb_addr == {4'hE, loc_addr[13:0]}));

  assert_wr_readback_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && !reg_sel) ##1 !reg_sel |-> (reg_rdata == $past(reg_wdata)));

  assert_ovl_cond_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ovl_sel |-> (dbg_active && page_hit && loc_addr[15:8] == 8'hBF));
endmodule

bind pgx_top pgx_chk u_chk (.*);

// File: tb/sim_pgx_top.sv
module sim_pgx_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [15:0] loc_addr;
  logic        dbg_access, dbg_page_en, dbg_active;
  logic        reg_sel, reg_we;
  logic [7:0]  reg_wdata;
  logic [7:0]  reg_rdata;
  logic [17:0] glb_addr;
  logic        ovl_sel, page_hit;

  int n_tests = 0;
  int n_fail  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pgx_top u0 (
    .clk(clk), .rst_n(rst_n), .loc_addr(loc_addr), .dbg_access(dbg_access),
    .dbg_page_en(dbg_page_en), .dbg_active(dbg_active), .reg_sel(reg_sel),
    .reg_we(reg_we), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .glb_addr(glb_addr), .ovl_sel(ovl_sel), .page_hit(page_hit)
  );

  task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", what, act, exp);
    end
  endtask

  task automatic settle();
    @(negedge clk); #1;
  endtask

  task automatic wr(input logic sel, input logic [7:0] d);
    @(negedge clk);
    reg_sel = sel; reg_we = 1'b1; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
    #1;
  endtask

  task automatic t_reset();
    reg_sel = 1'b0; settle();
    chk("R4 cpu page after reset", reg_rdata, 8'h00);
    reg_sel = 1'b1; settle();
    chk("R4 dbg page after reset", reg_rdata, 8'h00);
    reg_sel = 1'b0;
    loc_addr = 16'h9234; settle();
    chk("R1 window with page 0", glb_addr, {4'h0, 14'h1234});
  endtask

  task automatic t_window();
    wr(1'b0, 8'h07);
    chk("R4 cpu readback", reg_rdata, 8'h07);
    loc_addr = 16'h8000; settle();
    chk("R1 window low edge", glb_addr, {4'h7, 14'h0000});
    chk("R1 page_hit low edge", page_hit, 1'b1);
    loc_addr = 16'hBFFF; settle();
    chk("R1 window high edge", glb_addr, {4'h7, 14'h3FFF});
    chk("R1 page_hit high edge", page_hit, 1'b1);
  endtask

  task automatic t_fixed();
    loc_addr = 16'hC000; settle();
    chk("R2 top low edge", glb_addr, {4'hF, 14'h0000});
    chk("R2 no hit", page_hit, 1'b0);
    loc_addr = 16'hFFFE; settle();
    chk("R2 top high", glb_addr, {4'hF, 14'h3FFE});
    loc_addr = 16'h7FFF; settle();
    chk("R3 mid high edge", glb_addr, {4'hE, 14'h3FFF});
    chk("R3 mid no hit", page_hit, 1'b0);
    loc_addr = 16'h0123; settle();
    chk("R3 low block", glb_addr, {4'h0, 14'h0123});
  endtask

  task automatic t_low4();
    wr(1'b0, 8'hA5);
    chk("R5 full byte stored", reg_rdata, 8'hA5);
    loc_addr = 16'hA010; settle();
    chk("R5 only low bits used", glb_addr, {4'h5, 14'h2010});
    loc_addr = 16'hD010; settle();
    chk("R2 top ignores page", glb_addr, {4'hF, 14'h1010});
  endtask

  task automatic t_timing();
    loc_addr = 16'h8abc;
    @(negedge clk);
    reg_sel = 1'b0; reg_we = 1'b1; reg_wdata = 8'h0C;
    #1;
    chk("R6 addr before edge", glb_addr, {4'h5, 14'h0abc});
    chk("R6 rdata before edge", reg_rdata, 8'hA5);
    @(negedge clk);
    reg_we = 1'b0; #1;
    chk("R6 addr after edge", glb_addr, {4'hC, 14'h0abc});
    chk("R6 rdata after edge", reg_rdata, 8'h0C);
  endtask

  task automatic t_dbgsel();
    wr(1'b1, 8'h33);
    chk("R4 dbg readback", reg_rdata, 8'h33);
    reg_sel = 1'b0;
    loc_addr = 16'h8100;
    dbg_access = 1'b1; dbg_page_en = 1'b0; settle();
    chk("R7 feature off uses cpu", glb_addr, {4'hC, 14'h0100});
    dbg_access = 1'b0; dbg_page_en = 1'b1; settle();
    chk("R7 cpu access uses cpu", glb_addr, {4'hC, 14'h0100});
    dbg_access = 1'b1; settle();
    chk("R7 debug access uses dbg", glb_addr, {4'h3, 14'h0100});
    chk("R7 page_hit on dbg path", page_hit, 1'b1);
    loc_addr = 16'hE000; settle();
    chk("R2 top on dbg path", glb_addr, {4'hF, 14'h2000});
    dbg_access = 1'b0; dbg_page_en = 1'b0;
  endtask

  task automatic t_overlay();
    loc_addr = 16'hBF40;
    dbg_active = 1'b1;
    wr(1'b0, 8'h0F);
    chk("R8 near match 0x0F no overlay", ovl_sel, 1'b0);
    wr(1'b0, 8'hFF);
    chk("R8 overlay set", ovl_sel, 1'b1);
    loc_addr = 16'hBEFF; settle();
    chk("R8 below region", ovl_sel, 1'b0);
    loc_addr = 16'hBFFF; settle();
    chk("R8 region top", ovl_sel, 1'b1);
    loc_addr = 16'hFF40; settle();
    chk("R8 unpaged alias", ovl_sel, 1'b0);
    loc_addr = 16'hBF00;
    dbg_active = 1'b0; settle();
    chk("R8 not in debug mode", ovl_sel, 1'b0);
  endtask

  initial begin
    #(CLK_PERIOD * 5000);
    n_tests++; n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; loc_addr = 16'h0000;
    dbg_access = 1'b0; dbg_page_en = 1'b0; dbg_active = 1'b0;
    reg_sel = 1'b0; reg_we = 1'b0; reg_wdata = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_window();
    t_fixed();
    t_low4();
    t_timing();
    t_dbgsel();
    t_overlay();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule